// File: doc/BRIEF.md
# Gated Wakeup Flag Controller

This block keeps eight wakeup flags for a small sequencer core. Flags 0 to 3 are programmable. Each one has an enable bit and a source select that picks one line from a vector of event inputs, and the flag sets on a rising edge of that line. Flags 4 to 7 are set by software through a trigger register. Every set flag requests a wakeup. The combined request leaves the block through a gate that software opens and closes. The lowest-numbered set flag also chooses a vector index, taken from a per-flag mapping table, which tells the core what to run.

Software clears a flag by holding its bit high in a clear register. While that bit stays high the flag cannot set again. The gate protects the programmable side: a programmable flag can only be cleared, and its configuration can only be changed, while the gate is closed. Software flags can be cleared at any time. All registers are written over a single-cycle valid/address/data bus, and the flags are visible directly on an output port.

Top module: `wake_flag_ctrl`

## Requirements
- R1: After reset all flags are 0, the gate is open (1), every programmable enable is 0 with source select 0, the clear register is 0, and mapping entry j holds j. With no flag set, `vecValid` is 0 and `vecIdx` is 0.
- R2: Programmable flag i (0..3) sets on the clock edge that first samples a rising edge of `evIn[sel]`, where its configuration word at address 4+i holds the enable in bit 7 and sel in bits 2:0. A level that stays high, or an edge while the enable is 0, does not set it.
- R3: A write to address 2 with bit k set sets flag 4+k on that write's clock edge.
- R4: Address 1 is the clear register, with one bit per flag. While bit n is 1 (for flag n, when clearing is allowed), flag n is 0 from the following edge on. While bit n is 1, no set of flag n takes effect. Sets work again once 0 has been written back.
- R5: A held clear bit for a programmable flag clears it only while the gate is closed. With the gate open, the flag keeps its value.
- R6: Writes to the configuration words at addresses 4 to 7 are ignored while the gate (address 0, bit 0) is open.
- R7: Software flags 4 to 7 clear through the clear register whether the gate is open or closed.
- R8: `wakeOut` is 1 exactly when at least one flag is set and the gate is open.
- R9: `vecIdx` is the mapping entry (address 8+j, bits 2:0) of the lowest-numbered set flag j, and `vecValid` is 1 when any flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busValid | input | 1 | Write strobe |
| busAddr | input | 4 | Register address |
| busWdata | input | 8 | Write data |
| evIn | input | 8 | Event source lines |
| flags | output | 8 | Current wakeup flags |
| wakeOut | output | 1 | Gated combined wakeup request |
| vecValid | output | 1 | Some flag is set |
| vecIdx | output | 3 | Vector index of lowest set flag |

## Verification
Two functions can land on the same cycle: a rising edge on a programmable flag's source, and the bus write that releases that flag's clear bit. The bench drives both on one clock edge, with the clear bit still registered as 1 during that edge. The edge must be lost and the flag must stay 0. The same bench also runs a long stretch of random writes and event toggles, so gate changes, held clears and triggers overlap freely. A behavioural model compares all outputs every cycle during that stretch.

// File: rtl/wfc_pkg.sv
package wfc_pkg;
  localparam int PROG_N = 4;
  localparam int SW_N   = 4;
  localparam int FLAG_N = PROG_N + SW_N;

  // strobes from control to datapath
  typedef struct packed {
    logic [FLAG_N-1:0] clrNow;   // clear permitted and requested this cycle
    logic [FLAG_N-1:0] clrHeld;  // clear bit held: blocks any set
    logic [SW_N-1:0]   swSet;    // software trigger pulses
  } wfcStrobe_t;
endpackage

// File: rtl/wfc_ctrl.sv
module wfc_ctrl
  import wfc_pkg::*;
#(
  parameter int SRC_N  = 8,
  parameter int VEC_W  = 3,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           busValid,
  input  logic [ADDR_W-1:0]              busAddr,
  input  logic [DATA_W-1:0]              busWdata,
  output wfcStrobe_t                     strobe,
  output logic                           gateEn,
  output logic [PROG_N-1:0]              progEn,
  output logic [PROG_N-1:0][$clog2(SRC_N)-1:0] progSel,
  output logic [FLAG_N-1:0][VEC_W-1:0]   vecMap
);
  localparam int SEL_W     = $clog2(SRC_N);
  localparam int ADDR_GATE = 0;
  localparam int ADDR_CLR  = 1;
  localparam int ADDR_SWT  = 2;
  localparam int CFG_BASE  = 4;
  localparam int MAP_BASE  = 8;

  logic [FLAG_N-1:0] clrReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      gateEn  <= 1'b1;
      clrReg  <= '0;
      progEn  <= '0;
      progSel <= '0;
      for (int j = 0; j < FLAG_N; j++) vecMap[j] <= VEC_W'(j);
    end else if (busValid) begin
      if (busAddr == ADDR_W'(ADDR_GATE)) gateEn <= busWdata[0];
      if (busAddr == ADDR_W'(ADDR_CLR))  clrReg <= busWdata[FLAG_N-1:0];
      for (int k = 0; k < PROG_N; k++) begin
        if (busAddr == ADDR_W'(CFG_BASE + k) && !gateEn) begin
          progEn[k]  <= busWdata[DATA_W-1];
          progSel[k] <= busWdata[SEL_W-1:0];
        end
      end
      for (int j = 0; j < FLAG_N; j++) begin
        if (busAddr == ADDR_W'(MAP_BASE + j)) vecMap[j] <= busWdata[VEC_W-1:0];
      end
    end
  end

  always_comb begin
    strobe.swSet   = (busValid && busAddr == ADDR_W'(ADDR_SWT)) ? busWdata[SW_N-1:0] : '0;
    strobe.clrHeld = clrReg;
  end

  for (genvar i = 0; i < FLAG_N; i++) begin : gClr
    if (i < PROG_N) begin : gProg
      assign strobe.clrNow[i] = clrReg[i] & ~gateEn;
    end else begin : gSw
      assign strobe.clrNow[i] = clrReg[i];
    end
  end

  // R6: configuration frozen while the gate is open
  p_cfg_locked_r6: assert property (@(posedge clk) disable iff (rst)
    gateEn |=> ($stable(progEn) && $stable(progSel)));
endmodule

// File: rtl/wfc_datapath.sv
module wfc_datapath
  import wfc_pkg::*;
#(
  parameter int SRC_N = 8,
  parameter int VEC_W = 3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [SRC_N-1:0]               evIn,
  input  wfcStrobe_t                     strobe,
  input  logic                           gateEn,
  input  logic [PROG_N-1:0]              progEn,
  input  logic [PROG_N-1:0][$clog2(SRC_N)-1:0] progSel,
  input  logic [FLAG_N-1:0][VEC_W-1:0]   vecMap,
  output logic [FLAG_N-1:0]              flags,
  output logic                           wakeOut,
  output logic                           vecValid,
  output logic [VEC_W-1:0]               vecIdx
);
  logic [SRC_N-1:0]  evPrev;
  logic [SRC_N-1:0]  evRise;
  logic [FLAG_N-1:0] setReq;

  always_ff @(posedge clk) begin
    if (rst) evPrev <= '0;
    else     evPrev <= evIn;
  end
  assign evRise = evIn & ~evPrev;

  for (genvar i = 0; i < FLAG_N; i++) begin : gFlag
    if (i < PROG_N) begin : gProg
      assign setReq[i] = progEn[i] & evRise[progSel[i]];
      // R5: held clear with the gate open leaves the flag alone
      p_gate_keeps_r5: assert property (@(posedge clk) disable iff (rst)
        (gateEn && strobe.clrHeld[i]) |=> (flags[i] == $past(flags[i])));
      // R2: enabled source edge sets the flag
      p_edge_sets_r2: assert property (@(posedge clk) disable iff (rst)
        (setReq[i] && !strobe.clrHeld[i]) |=> flags[i]);
    end else begin : gSw
      assign setReq[i] = strobe.swSet[i-PROG_N];
      // R3: trigger write sets the software flag
      p_sw_sets_r3: assert property (@(posedge clk) disable iff (rst)
        (strobe.swSet[i-PROG_N] && !strobe.clrHeld[i]) |=> flags[i]);
    end

    always_ff @(posedge clk) begin
      if (rst)                                     flags[i] <= 1'b0;
      else if (strobe.clrNow[i])                   flags[i] <= 1'b0;
      else if (setReq[i] && !strobe.clrHeld[i])    flags[i] <= 1'b1;
    end

    // R4: permitted clear empties the flag; a held bit blocks new sets
    p_clear_takes_r4: assert property (@(posedge clk) disable iff (rst)
      strobe.clrNow[i] |=> !flags[i]);
    p_held_blocks_r4: assert property (@(posedge clk) disable iff (rst)
      (strobe.clrHeld[i] && !flags[i]) |=> !flags[i]);
  end

  always_comb begin
    vecIdx = '0;
    for (int j = FLAG_N - 1; j >= 0; j--) begin
      if (flags[j]) vecIdx = vecMap[j];
    end
  end
  assign vecValid = |flags;
  assign wakeOut  = vecValid & gateEn;
endmodule

// File: rtl/wake_flag_ctrl.sv
module wake_flag_ctrl
  import wfc_pkg::*;
#(
  parameter int SRC_N  = 8,
  parameter int VEC_W  = 3,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [SRC_N-1:0]  evIn,
  output logic [FLAG_N-1:0] flags,
  output logic              wakeOut,
  output logic              vecValid,
  output logic [VEC_W-1:0]  vecIdx
);
  localparam int SEL_W = $clog2(SRC_N);

  wfcStrobe_t                     strobe;
  logic                           gateEn;
  logic [PROG_N-1:0]              progEn;
  logic [PROG_N-1:0][SEL_W-1:0]   progSel;
  logic [FLAG_N-1:0][VEC_W-1:0]   vecMap;

  wfc_ctrl #(.SRC_N(SRC_N), .VEC_W(VEC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rst(rst), .busValid(busValid), .busAddr(busAddr), .busWdata(busWdata),
    .strobe(strobe), .gateEn(gateEn), .progEn(progEn), .progSel(progSel), .vecMap(vecMap)
  );

  wfc_datapath #(.SRC_N(SRC_N), .VEC_W(VEC_W)) uData (
    .clk(clk), .rst(rst), .evIn(evIn), .strobe(strobe), .gateEn(gateEn),
    .progEn(progEn), .progSel(progSel), .vecMap(vecMap),
    .flags(flags), .wakeOut(wakeOut), .vecValid(vecValid), .vecIdx(vecIdx)
  );

  // R8: the gated output never fires without a flag
  p_wake_needs_flag_r8: assert property (@(posedge clk) disable iff (rst)
    wakeOut |-> (flags != '0));
endmodule

// File: tb/tb_wake_flag_ctrl.sv
module tb_wake_flag_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       busValid = 1'b0;
  logic [3:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] evIn = '0;
  logic [7:0] flags;
  logic       wakeOut, vecValid;
  logic [2:0] vecIdx;

  always #2 clk = ~clk;  // 250 MHz

  wake_flag_ctrl dut (
    .clk(clk), .rst(rst), .busValid(busValid), .busAddr(busAddr), .busWdata(busWdata),
    .evIn(evIn), .flags(flags), .wakeOut(wakeOut), .vecValid(vecValid), .vecIdx(vecIdx)
  );

  int    nChecks = 0;
  int    nFails  = 0;
  int    cyc     = 0;
  string curTag  = "R1";
  bit    done    = 0;

  // behavioural reference
  bit       mFlag[8];
  bit       mClr[8];
  bit       mEn[4];
  int       mSel[4];
  int       mMap[8];
  bit       mGate;
  bit [7:0] mPrev;

  always @(posedge clk) begin
    bit nf[8];
    bit clrOk, setOk;
    if (rst) begin
      for (int i = 0; i < 8; i++) begin mFlag[i] = 0; mClr[i] = 0; mMap[i] = i; end
      for (int i = 0; i < 4; i++) begin mEn[i] = 0; mSel[i] = 0; end
      mGate = 1; mPrev = '0;
    end else begin
      for (int i = 0; i < 8; i++) begin
        clrOk = mClr[i] && (i >= 4 || !mGate);
        if (i < 4) setOk = mEn[i] && evIn[mSel[i]] && !mPrev[mSel[i]];
        else       setOk = busValid && busAddr == 2 && busWdata[i-4];
        if (clrOk)                   nf[i] = 0;
        else if (setOk && !mClr[i])  nf[i] = 1;
        else                         nf[i] = mFlag[i];
      end
      if (busValid) begin
        if (busAddr >= 4 && busAddr <= 7 && !mGate) begin
          mEn[busAddr-4]  = busWdata[7];
          mSel[busAddr-4] = int'(busWdata[2:0]);
        end
        if (busAddr == 0) mGate = busWdata[0];
        if (busAddr == 1) for (int i = 0; i < 8; i++) mClr[i] = busWdata[i];
        if (busAddr >= 8) mMap[busAddr-8] = int'(busWdata[2:0]);
      end
      for (int i = 0; i < 8; i++) mFlag[i] = nf[i];
      mPrev = evIn;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    int ef, ei;
    bit ev;
    if (!rst && !done) begin
      ef = 0; ei = 0; ev = 0;
      for (int i = 7; i >= 0; i--) if (mFlag[i]) begin ef |= (1 << i); ei = mMap[i]; ev = 1; end
      check({curTag, " flags"}, int'(flags), ef);
      check({curTag, " R8 wake"}, int'(wakeOut), int'(ev && mGate));
      check({curTag, " R9 valid"}, int'(vecValid), int'(ev));
      check({curTag, " R9 index"}, int'(vecIdx), ei);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      nFails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    busValid = 1; busAddr = 4'(a); busWdata = 8'(d);
    @(negedge clk);
    busValid = 0;
  endtask

  task automatic ev(input int v);
    @(negedge clk);
    evIn = 8'(v);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    @(negedge clk); rst = 0;
    idle(1);
    // R1: reset state
    curTag = "R1";
    check("R1 flags", int'(flags), 0);
    check("R1 wake", int'(wakeOut), 0);
    check("R1 index", int'(vecIdx), 0);

    // R2: programmable set on selected rising edge
    curTag = "R2";
    wr(0, 0);
    wr(4, 8'h82);     // flag0 enabled, source 2
    wr(5, 8'h85);     // flag1 enabled, source 5
    wr(6, 8'h03);     // flag2 disabled, source 3
    wr(0, 1);
    ev(8'h0C); idle(2);
    check("R2 edge sets flag0, disabled flag2 stays", int'(flags), 8'h01);
    check("R8 wake with gate open", int'(wakeOut), 1);
    idle(3);
    check("R2 level holds no new set", int'(flags), 8'h01);
    ev(8'h2C); idle(2);
    check("R2 source 5 sets flag1", int'(flags), 8'h03);

    // R3: software trigger
    curTag = "R3";
    wr(2, 4'b0101); idle(1);
    check("R3 trigger sets 4 and 6", int'(flags), 8'h53);

    // R9: mapping table
    curTag = "R9";
    wr(8, 7); idle(1);
    check("R9 mapped index of flag0", int'(vecIdx), 7);

    // R5: clear held with gate open is refused
    curTag = "R5";
    wr(1, 8'h01); idle(3);
    check("R5 gate open keeps flag0", int'(flags), 8'h53);
    wr(0, 0); idle(2);
    check("R5 gate closed clears flag0", int'(flags), 8'h52);
    check("R8 wake masked by closed gate", int'(wakeOut), 0);
    check("R9 next lowest flag1", int'(vecIdx), 1);

    // R4: held clear blocks sets until released
    curTag = "R4";
    ev(8'h28); ev(8'h2C); idle(2);
    check("R4 edge blocked while held", int'(flags), 8'h52);
    wr(1, 0);
    ev(8'h28); ev(8'h2C); idle(2);
    check("R4 edge sets after release", int'(flags), 8'h53);

    // R6: config writes ignored with gate open
    curTag = "R6";
    wr(1, 8'h01); idle(1); wr(1, 0);
    wr(0, 1);
    wr(4, 8'h81);     // would move flag0 to source 1: ignored
    ev(8'h2E); idle(2);
    check("R6 source 1 edge ignored", int'(flags), 8'h52);
    ev(8'h2A); ev(8'h2E); idle(2);
    check("R6 original source 2 still active", int'(flags), 8'h53);

    // R7: software clears with gate open
    curTag = "R7";
    wr(1, 8'h50); idle(2);
    check("R7 sw flags cleared with gate open", int'(flags), 8'h03);
    wr(1, 0);

    // R4 collision: release write and source edge on the same edge
    curTag = "R4 collision";
    wr(0, 0);
    wr(1, 8'h02); idle(1);
    ev(8'h0C);        // source 5 low
    @(negedge clk);
    busValid = 1; busAddr = 4'd1; busWdata = 8'h00; evIn = 8'h2C;
    @(negedge clk);
    busValid = 0;
    idle(2);
    check("R4 edge during release edge is lost", int'(flags[1]), 0);

    // mixed random traffic checked by the model
    curTag = "R2 R4 R5 R6 R7 random";
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      busValid = ($urandom_range(0, 2) == 0);
      case ($urandom_range(0, 5))
        0: busAddr = 4'd0;
        1: busAddr = 4'd1;
        2: busAddr = 4'd2;
        3: busAddr = 4'(4 + $urandom_range(0, 3));
        4: busAddr = 4'(8 + $urandom_range(0, 7));
        default: busAddr = 4'd0;
      endcase
      busWdata = 8'($urandom);
      if ($urandom_range(0, 1) == 0) evIn = evIn ^ (8'h01 << $urandom_range(0, 7));
    end
    @(negedge clk); busValid = 0;
    idle(3);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule